// File: doc/BRIEF.md
# Multi-ID Selection Responder

This block decides whether a controller sitting on a 16-bit wide SCSI bus answers a selection or reselection. Software programs a 16-bit enable mask through a byte-wide register port. Each mask bit lets the controller answer to one bus ID. A separate 4-bit register holds the one ID the controller uses when it arbitrates.

The block samples the bus ID lines and the SEL, BSY and I/O signals once per clock. It raises a ready flag as soon as a selection it may answer is on the bus. It raises the actual response only after the same pattern has held for a programmable settle time. At that moment it latches the encoded ID it was selected as, and whether the phase was a reselection. During arbitration it reports whether its own ID is the highest-priority ID on the bus. A live offset-zero input from the transfer logic is passed through to the status byte unchanged.

Top module: `scsi_id_responder`

## Requirements
- R1: Register map on `reg_addr`. Address 0 holds mask bits for IDs 7..0 and address 1 holds mask bits for IDs 15..8, with bit k of each byte covering the k-th ID of that byte. Address 2 holds the arbitration ID in bits 3:0, and its bits 7:4 read as 0. Address 3 is the read-only status byte, and writes to it are ignored.
- R2: After reset both mask bytes and the arbitration ID read 0. Status bits 7:3 read 0, and status bits 1:0 read 11 while `offset_zero` is 1.
- R3: `sel_ready` and status bit 3 are 1 one clock after the bus shows all of the following: SEL high, BSY low, at least one asserted ID line enabled in the mask, and no more than two ID lines asserted in total. Otherwise they are 0.
- R4: `sel_response` goes high SETTLE_CYCLES clocks after `sel_ready` first rose, provided the ID lines and I/O did not change in between. It falls in the same cycle as `sel_ready`.
- R5: When the response starts, the encoded matched ID (0 to 15) appears on `sel_id` and in status bits 7:4. It keeps that value until the next response.
- R6: When two enabled IDs are on the bus, the captured ID is the higher-priority one. The priority order is ID 7 highest down to ID 0, then ID 15 down to ID 8.
- R7: `sel_resel` is set to the sampled I/O level when the response starts: 1 means reselection and 0 means selection.
- R8: A change of the ID lines or of I/O while the settle time is running restarts the settle time from that change.
- R9: On each clock after `arb_active` was sampled high, `arb_won` and status bit 2 are updated. They become 1 if the arbitration ID's line is the highest-priority asserted line under the R6 order, ignoring the mask, and 0 otherwise. While `arb_active` is low they hold their value.
- R10: Status bit 1 follows `offset_zero` in the same cycle. Status bit 0 is the inverse of `sel_response`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_id | input | 16 | ID/data lines, 1 = asserted |
| bus_sel | input | 1 | SEL asserted |
| bus_bsy | input | 1 | BSY asserted |
| bus_io | input | 1 | I/O asserted |
| arb_active | input | 1 | Arbitration phase in progress |
| offset_zero | input | 1 | Live synchronous offset-is-zero flag |
| sel_ready | output | 1 | Ready to be selected (no settle wait) |
| sel_response | output | 1 | Settled response to selection |
| sel_resel | output | 1 | Last response was a reselection |
| sel_id | output | 4 | Encoded ID last selected as |
| arb_won | output | 1 | Own ID won the last arbitration sample |

## Verification
The bench uses several kinds of bus pattern. A single initiator plus one enabled target is the baseline for timing and capture. A reselection on an upper-byte ID exercises I/O capture and the high mask byte. Two enabled IDs at once, in both byte halves, separate the wrap-around priority order from a plain binary order. Three asserted lines, BSY high, and only disabled IDs each show that one acceptance condition blocks the ready flag. A mid-settle ID change shows the counter restarts instead of carrying over. The arbitration patterns include IDs outside the mask to show that arbitration ignores it.

// File: rtl/scsi_resp_pkg.sv
`timescale 1ns/1ps
package scsi_resp_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic sel;
    logic bsy;
    logic io;
    logic arb;
  } bus_ctl_t;
endpackage

// File: rtl/id_prio_enc.sv
`timescale 1ns/1ps
// Priority encoder: the lower half of the IDs outranks the upper half,
// and inside each half the higher index wins.
module id_prio_enc #(
  parameter int NUM_IDS = 16,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input  logic [NUM_IDS-1:0] vec,
  output logic               found,
  output logic [ID_W-1:0]    idx
);
  localparam int HALF = NUM_IDS / 2;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    // k walks ranks from lowest to highest; the last hit wins
    for (int k = 0; k < NUM_IDS; k++) begin
      if (vec[k ^ HALF]) begin
        found = 1'b1;
        idx   = ID_W'(k ^ HALF);
      end
    end
  end
endmodule

// File: rtl/resp_regs.sv
`timescale 1ns/1ps
module resp_regs #(
  parameter int NUM_IDS = 16,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int NBYTES = NUM_IDS / scsi_resp_pkg::BYTE_W,
  localparam int ADDR_W = $clog2(NBYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        status,
  output logic [7:0]        rdata,
  output logic [NUM_IDS-1:0] mask,
  output logic [ID_W-1:0]   own_id
);
  localparam logic [ADDR_W-1:0] A_OWN    = ADDR_W'(NBYTES);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(NBYTES + 1);

  logic [NUM_IDS-1:0] mask_d;
  logic [ID_W-1:0]    own_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    always_comb begin
      mask_d[b*8 +: 8] = mask[b*8 +: 8];
      if (we && addr == ADDR_W'(b)) mask_d[b*8 +: 8] = wdata;
    end
  end

  always_comb begin
    own_d = own_id;
    if (we && addr == A_OWN) own_d = wdata[ID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      own_id <= '0;
    end else begin
      mask   <= mask_d;
      own_id <= own_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBYTES; b++)
      if (addr == ADDR_W'(b)) rdata = mask[b*8 +: 8];
    if (addr == A_OWN)    rdata = 8'(own_id);
    if (addr == A_STATUS) rdata = status;
  end
endmodule

// File: rtl/sel_match.sv
`timescale 1ns/1ps
module sel_match #(
  parameter int NUM_IDS       = 16,
  parameter int SETTLE_CYCLES = 20,
  localparam int ID_W  = $clog2(NUM_IDS),
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDS-1:0] id_q,
  input  logic               sel_q,
  input  logic               bsy_q,
  input  logic               io_q,
  input  logic [NUM_IDS-1:0] id_raw,
  input  logic               io_raw,
  input  logic [NUM_IDS-1:0] mask,
  output logic               ready,
  output logic               response,
  output logic               resel,
  output logic [ID_W-1:0]    sel_id
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(SETTLE_CYCLES - 1);

  logic [NUM_IDS-1:0] hits;
  logic               hit_found;
  logic [ID_W-1:0]    hit_idx;
  logic               changing;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ID_W-1:0]    id_d;
  logic               resel_d;
  logic               capture;

  assign hits = id_q & mask;

  id_prio_enc #(.NUM_IDS(NUM_IDS)) u_enc (
    .vec   (hits),
    .found (hit_found),
    .idx   (hit_idx)
  );

  assign ready    = sel_q && !bsy_q && hit_found && ($countones(id_q) <= 2);
  assign changing = (id_raw != id_q) || (io_raw != io_q);
  assign capture  = ready && !changing && (cnt_q == CNT_CAP);
  assign response = ready && (cnt_q == CNT_END);

  always_comb begin
    if (!ready || changing)   cnt_d = '0;
    else if (cnt_q != CNT_END) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_comb begin
    id_d    = sel_id;
    resel_d = resel;
    if (capture) begin
      id_d    = hit_idx;
      resel_d = io_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sel_id <= '0;
      resel  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sel_id <= id_d;
      resel  <= resel_d;
    end
  end
endmodule

// File: rtl/arb_check.sv
`timescale 1ns/1ps
module arb_check #(
  parameter int NUM_IDS = 16,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_q,
  input  logic [NUM_IDS-1:0] id_q,
  input  logic [ID_W-1:0]    own_id,
  output logic               won
);
  logic            top_found;
  logic [ID_W-1:0] top_idx;
  logic            won_d;

  id_prio_enc #(.NUM_IDS(NUM_IDS)) u_enc (
    .vec   (id_q),
    .found (top_found),
    .idx   (top_idx)
  );

  always_comb begin
    won_d = won;
    if (arb_q) won_d = top_found && (top_idx == own_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) won <= 1'b0;
    else        won <= won_d;
  end
endmodule

// File: rtl/scsi_id_responder.sv
`timescale 1ns/1ps
module scsi_id_responder #(
  parameter int NUM_IDS       = 16,
  parameter int SETTLE_CYCLES = 20,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int NBYTES = NUM_IDS / scsi_resp_pkg::BYTE_W,
  localparam int ADDR_W = $clog2(NBYTES + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [NUM_IDS-1:0] bus_id,
  input  logic               bus_sel,
  input  logic               bus_bsy,
  input  logic               bus_io,
  input  logic               arb_active,
  input  logic               offset_zero,
  output logic               sel_ready,
  output logic               sel_response,
  output logic               sel_resel,
  output logic [ID_W-1:0]    sel_id,
  output logic               arb_won
);
  import scsi_resp_pkg::*;

  logic [NUM_IDS-1:0] id_q;
  bus_ctl_t           ctl_q, ctl_d;
  logic [NUM_IDS-1:0] resp_mask;
  logic [ID_W-1:0]    own_id;
  logic [7:0]         status;

  always_comb begin
    ctl_d.sel = bus_sel;
    ctl_d.bsy = bus_bsy;
    ctl_d.io  = bus_io;
    ctl_d.arb = arb_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      ctl_q <= '0;
    end else begin
      id_q  <= bus_id;
      ctl_q <= ctl_d;
    end
  end

  // status byte: selected-as ID, ready, arbitration won, offset zero, idle
  assign status = {sel_id, sel_ready, arb_won, offset_zero, ~sel_response};

  resp_regs #(.NUM_IDS(NUM_IDS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .status (status),
    .rdata  (reg_rdata),
    .mask   (resp_mask),
    .own_id (own_id)
  );

  sel_match #(.NUM_IDS(NUM_IDS), .SETTLE_CYCLES(SETTLE_CYCLES)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_q     (id_q),
    .sel_q    (ctl_q.sel),
    .bsy_q    (ctl_q.bsy),
    .io_q     (ctl_q.io),
    .id_raw   (bus_id),
    .io_raw   (bus_io),
    .mask     (resp_mask),
    .ready    (sel_ready),
    .response (sel_response),
    .resel    (sel_resel),
    .sel_id   (sel_id)
  );

  arb_check #(.NUM_IDS(NUM_IDS)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .arb_q  (ctl_q.arb),
    .id_q   (id_q),
    .own_id (own_id),
    .won    (arb_won)
  );
endmodule

// File: rtl/resp_checker.sv
`timescale 1ns/1ps
module resp_checker #(
  parameter int NUM_IDS = 16,
  localparam int ID_W = $clog2(NUM_IDS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_bsy,
  input logic               sel_ready,
  input logic               sel_response,
  input logic [ID_W-1:0]    sel_id,
  input logic [NUM_IDS-1:0] resp_mask,
  input logic               arb_q,
  input logic               arb_won
);
  AST_READY_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ready |-> $past(bus_sel && !bus_bsy)); // R3
  AST_RESP_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_response |-> sel_ready); // R4
  AST_RESP_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_response) |-> $past(sel_ready)); // R4
  AST_ID_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_response) |-> resp_mask[sel_id]); // R5
  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_response && $past(sel_response)) |-> $stable(sel_id)); // R5
  AST_ARB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_q |=> $stable(arb_won)); // R9
endmodule

bind scsi_id_responder resp_checker #(.NUM_IDS(NUM_IDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_bsy      (bus_bsy),
  .sel_ready    (sel_ready),
  .sel_response (sel_response),
  .sel_id       (sel_id),
  .resp_mask    (resp_mask),
  .arb_q        (ctl_q.arb),
  .arb_won      (arb_won)
);

// File: tb/sim_scsi_id_responder.sv
`timescale 1ns/1ps
module sim_scsi_id_responder;
  localparam int S = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_id;
  logic        bus_sel, bus_bsy, bus_io, arb_active, offset_zero;
  logic        sel_ready, sel_response, sel_resel, arb_won;
  logic [3:0]  sel_id;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  scsi_id_responder #(.NUM_IDS(16), .SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_id(bus_id),
    .bus_sel(bus_sel), .bus_bsy(bus_bsy), .bus_io(bus_io),
    .arb_active(arb_active), .offset_zero(offset_zero),
    .sel_ready(sel_ready), .sel_response(sel_response),
    .sel_resel(sel_resel), .sel_id(sel_id), .arb_won(arb_won)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [15:0] id, input logic sel, input logic bsy, input logic io);
    bus_id = id; bus_sel = sel; bus_bsy = bsy; bus_io = io;
  endtask

  task automatic idle_bus();
    drive(16'h0, 1'b0, 1'b0, 1'b0);
    step(2);
  endtask

  // select with a pattern and check response timing and capture
  task automatic sel_run(input string req, input logic [15:0] id, input logic io,
                         input logic [3:0] exp_id);
    logic [7:0] st;
    drive(id, 1'b1, 1'b0, io);
    step(1);
    check({req, " ready after one clock (R3)"}, sel_ready, 1);
    step(S - 1);
    check({req, " no response before settle (R4)"}, sel_response, 0);
    step(1);
    check({req, " response after settle (R4)"}, sel_response, 1);
    check({req, " captured ID (R5)"}, sel_id, exp_id);
    check({req, " reselection flag (R7)"}, sel_resel, io);
    rd(2'd3, st);
    check({req, " status selected-as/ready/idle (R5 R10)"}, {st[7:3], st[0]}, {exp_id, 1'b1, 1'b0});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R2 mask low", d, 8'h00);
    rd(2'd1, d); check("R2 mask high", d, 8'h00);
    rd(2'd2, d); check("R2 own ID", d, 8'h00);
    rd(2'd3, d); check("R2 status", {d[7:3], d[1:0]}, 7'b0000011);
    check("R2 ready low", sel_ready, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hF7);
    rd(2'd0, d); check("R1 mask low readback", d, 8'hA5);
    rd(2'd1, d); check("R1 mask high readback", d, 8'h3C);
    rd(2'd2, d); check("R1 own ID upper bits zero", d, 8'h07);
    wr(2'd3, 8'hF0);
    rd(2'd3, d); check("R1 status write ignored", {d[7:3], d[1:0]}, 7'b0000011);
  endtask

  task automatic t_select();
    logic [7:0] st;
    // initiator ID 3 (disabled) and target ID 5 (enabled)
    sel_run("R5 single target", 16'h0028, 1'b0, 4'd5);
    drive(16'h0, 1'b0, 1'b0, 1'b0);
    step(1);
    check("R4 response drops with ready", {sel_ready, sel_response}, 2'b00);
    check("R5 ID held after release", sel_id, 4'd5);
    rd(2'd3, st);
    check("R10 idle bit back to 1", st[0], 1);
    step(1);
  endtask

  task automatic t_resel();
    // IDs 12 (enabled) and 1 (disabled), I/O asserted
    sel_run("R7 reselection", 16'h1002, 1'b1, 4'd12);
    idle_bus();
  endtask

  task automatic t_priority();
    // IDs 2 and 12 both enabled: lower byte outranks upper
    sel_run("R6 pick 2 over 12", 16'h1004, 1'b0, 4'd2);
    idle_bus();
    // IDs 13 and 10 both enabled: 13 outranks 10
    sel_run("R6 pick 13 over 10", 16'h2400, 1'b0, 4'd13);
    idle_bus();
    // IDs 0 and 7 both enabled: 7 outranks 0
    sel_run("R6 pick 7 over 0", 16'h0081, 1'b0, 4'd7);
    idle_bus();
  endtask

  task automatic t_reject();
    drive(16'h0068, 1'b1, 1'b0, 1'b0); // three lines 3,5,6
    step(S + 3);
    check("R3 three lines rejected", {sel_ready, sel_response}, 2'b00);
    idle_bus();
    drive(16'h0028, 1'b1, 1'b1, 1'b0); // BSY high
    step(S + 3);
    check("R3 BSY high rejected", {sel_ready, sel_response}, 2'b00);
    idle_bus();
    drive(16'h0018, 1'b1, 1'b0, 1'b0); // IDs 3,4 disabled
    step(S + 3);
    check("R3 disabled IDs rejected", {sel_ready, sel_response}, 2'b00);
    idle_bus();
  endtask

  task automatic t_restart();
    drive(16'h0028, 1'b1, 1'b0, 1'b0);
    step(S / 2);
    drive(16'h0088, 1'b1, 1'b0, 1'b0); // 3 and 7
    step(S);
    check("R8 settle restarted", sel_response, 0);
    step(1);
    check("R8 response after restart", sel_response, 1);
    check("R8 new ID captured", sel_id, 4'd7);
    idle_bus();
  endtask

  task automatic t_arb();
    logic [7:0] st;
    arb_active = 1'b1;
    drive(16'h1080, 1'b0, 1'b1, 1'b0); // 7 and 12, own 7
    step(2);
    check("R9 own 7 beats 12", arb_won, 1);
    rd(2'd3, st); check("R9 status bit 2", st[2], 1);
    arb_active = 1'b0;
    wr(2'd2, 8'h0C);
    step(1);
    arb_active = 1'b1;
    step(2);
    check("R9 own 12 loses to 7", arb_won, 0);
    arb_active = 1'b0;
    wr(2'd2, 8'h09);
    drive(16'h0300, 1'b0, 1'b1, 1'b0); // 8 and 9, neither enabled
    step(1);
    arb_active = 1'b1;
    step(2);
    check("R9 own 9 beats 8, mask ignored", arb_won, 1);
    arb_active = 1'b0;
    step(1);
    drive(16'h8000, 1'b0, 1'b1, 1'b0);
    step(3);
    check("R9 held while inactive", arb_won, 1);
    idle_bus();
  endtask

  task automatic t_offset();
    logic [7:0] st;
    offset_zero = 1'b0;
    rd(2'd3, st); check("R10 offset zero low", st[1], 0);
    offset_zero = 1'b1;
    rd(2'd3, st); check("R10 offset zero high", st[1], 1);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_id = '0; bus_sel = 1'b0; bus_bsy = 1'b0; bus_io = 1'b0;
    arb_active = 1'b0; offset_zero = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_select();
    t_resel();
    t_priority();
    t_reject();
    t_restart();
    t_arb();
    t_offset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule